// File: doc/BRIEF.md
# PLCP Receive Error Monitor

This block sits beside a physical layer convergence framer on the receive side. It counts three kinds of per-frame error events: framing pattern errors, BIP-8 parity errors and the remote error indication carried in the path status byte. It also reports the remote alarm bit, the present out-of-frame and loss-of-frame conditions, and sends a one-cycle request to the framer to restart its frame search. Frame pattern search, BIP-8 computation and host register decoding live elsewhere. The block only sees their per-cycle results.

Counting depends on the framer state. With the count-control input low, nothing is counted while the framer is out of frame. After the framer regains frame, parity counting waits out a short frame holdoff. With the count-control input high, every event is counted. A rising edge on the resync control input requests a new search. Once the framer then reports lock, counting proceeds even while out of frame. This bypass lasts until the out-of-frame condition clears.

Software reads counts through a snapshot strobe. The strobe copies the live counters into held registers and restarts the live counters in the same cycle. The nonzero flags describe the held values.

Top module: `plcp_rx_errmon`

## Requirements
- R1: With `cnt_all` low and `oof_in` high, and no forced-resync bypass active, framing errors, parity errors and REI values are not added to the live counters.
- R2: With `cnt_all` low, when `oof_in` falls a holdoff of 2 frame strobes is loaded. Parity errors are ignored in the cycle of the fall and until 2 `frame_stb` pulses have been seen. From the cycle after the second strobe, parity errors count again. Framing errors and REI are not held off.
- R3: With `cnt_all` high, all three error types are counted whatever the state of `oof_in`.
- R4: `force_search` is high for exactly one cycle, in the cycle after a cycle where `resync_ctl` is 1 and it was 0 in the cycle before. Holding `resync_ctl` high gives no further pulse.
- R5: After a `force_search` pulse, the first cycle with `lock_in` high starts a bypass. From the next cycle, all three error types are counted even while `oof_in` is high. The bypass ends when `oof_in` falls. A new `force_search` pulse cancels the bypass and waits for lock again.
- R6: `frm_nz`, `par_nz` and `rei_nz` are 1 exactly when the matching held count is nonzero.
- R7: In the cycle after a `frame_stb`, `rai_stat` equals bit 3 (the fifth bit counted from the MSB) of the `g1_byte` presented with that strobe. It keeps that value between strobes.
- R8: `oof_stat` and `lof_stat` equal `oof_in` and `lof_in` of the previous cycle, with no latching.
- R9: Each cycle with `frm_err` high adds 1 to the framing count. Each cycle with `par_err` high adds 1 to the parity count. Each `frame_stb` adds `g1_byte[7:4]` to the REI count. Each addition is subject to R1, R2, R3 and R5.
- R10: Every counter saturates at all ones (65535 at default width) and never wraps.
- R11: `snap_stb` copies the three live counts into the held outputs and clears the live counts in the same cycle. An event that is allowed to count in the snapshot cycle lands in the cleared live counter.
- R12: After reset, all held counts, flags, status bits and `force_search` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One pulse per received frame; qualifies `g1_byte` |
| frm_err | input | 1 | Framing pattern error event |
| par_err | input | 1 | BIP-8 parity error event |
| g1_byte | input | 8 | Path status byte: [7:4] REI value, [3] remote alarm |
| oof_in | input | 1 | Framer out-of-frame condition |
| lof_in | input | 1 | Line loss-of-frame condition |
| lock_in | input | 1 | Framer reports frame lock |
| cnt_all | input | 1 | Count-control: 1 counts during out-of-frame |
| resync_ctl | input | 1 | Rising edge requests a new frame search |
| snap_stb | input | 1 | Snapshot-and-clear strobe |
| force_search | output | 1 | One-cycle search request to the framer |
| frm_cnt | output | 16 | Held framing error count |
| par_cnt | output | 16 | Held parity error count |
| rei_cnt | output | 16 | Held REI count |
| frm_nz | output | 1 | Held framing count nonzero |
| par_nz | output | 1 | Held parity count nonzero |
| rei_nz | output | 1 | Held REI count nonzero |
| rai_stat | output | 1 | Remote alarm from the last status byte |
| oof_stat | output | 1 | Out-of-frame status |
| lof_stat | output | 1 | Loss-of-frame status |

## Verification
Every result is due one rising edge after the stimulus that causes it. This covers a counted event landing in the live counter, `force_search` after a rising `resync_ctl`, and the status bits after `oof_in`, `lof_in` or a frame strobe. Held counts and nonzero flags change only one edge after `snap_stb`, so counts are observed by snapshotting. The bench drives inputs just after a falling edge and advances a reference model by one step for the coming rising edge. It then compares every output on the following falling edge, so each expectation lines up with the register that produces it. The holdoff and bypass phases are driven by hand: the out-of-frame fall is placed mid-frame, and parity errors are applied on every cycle around the two following strobes.

// File: rtl/plcp_em_pkg.sv
`timescale 1ns/1ps
package plcp_em_pkg;

    // Counter slots, shared by the top and its generate loop.
    localparam int N_CTR   = 3;
    localparam int CTR_FRM = 0;
    localparam int CTR_PAR = 1;
    localparam int CTR_REI = 2;

    // Forced-resync tracker states.
    typedef enum logic [1:0] {
        RS_IDLE      = 2'd0,
        RS_WAIT_LOCK = 2'd1,
        RS_BYPASS    = 2'd2
    } rs_state_e;

    // Per-type count enables produced by the gating logic.
    typedef struct packed {
        logic frm;
        logic par;
        logic rei;
    } em_enable_t;

    // Path status byte fields.
    typedef struct packed {
        logic [3:0] rei;
        logic       rai;
        logic [2:0] spare;
    } g1_fields_t;

    function automatic g1_fields_t split_g1(input logic [7:0] b);
        g1_fields_t f;
        f.rei   = b[7:4];
        f.rai   = b[3];
        f.spare = b[2:0];
        return f;
    endfunction

endpackage

// File: rtl/plcp_em_counter.sv
`timescale 1ns/1ps
module plcp_em_counter #(
    parameter int W  = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          snap,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  live,
    output logic [W-1:0]  held
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] base;
    logic [W:0]   wide;
    logic [W-1:0] nxt;

    // A snapshot restarts the live count from zero; this cycle's event still lands.
    always_comb begin
        base = snap ? '0 : live;
        wide = {1'b0, base} + {{(W+1-IW){1'b0}}, (en ? inc : {IW{1'b0}})};
        nxt  = wide[W] ? TOP : wide[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
            held <= '0;
        end else begin
            live <= nxt;
            if (snap) held <= live;
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (live == TOP && !snap) |=> live == TOP);                          // R10
    AST_SNAP_COPY: assert property (@(posedge clk) disable iff (rst)
        snap |=> held == $past(live));                                    // R11
    AST_SNAP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (snap && !en) |=> live == '0);                                    // R11

endmodule

// File: rtl/plcp_em_gate.sv
`timescale 1ns/1ps
module plcp_em_gate
    import plcp_em_pkg::*;
#(
    parameter int HOLD_FRAMES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_stb,
    input  logic       oof_in,
    input  logic       lock_in,
    input  logic       cnt_all,
    input  logic       resync_ctl,
    output logic       force_search,
    output logic       bypass,
    output logic       hold_busy,
    output em_enable_t en
);
    localparam int HW = $clog2(HOLD_FRAMES + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_FRAMES);

    logic          oof_q;
    logic          res_q;
    logic          oof_fall;
    logic          res_rise;
    logic [HW-1:0] hold_cnt;
    rs_state_e     rs_st, rs_nxt;

    assign oof_fall  = oof_q & ~oof_in;
    assign res_rise  = resync_ctl & ~res_q;
    assign bypass    = (rs_st == RS_BYPASS);
    assign hold_busy = (hold_cnt != '0);

    always_comb begin
        rs_nxt = rs_st;
        if (res_rise)
            rs_nxt = RS_WAIT_LOCK;
        else if (rs_st == RS_WAIT_LOCK && lock_in)
            rs_nxt = RS_BYPASS;
        else if (rs_st == RS_BYPASS && oof_fall)
            rs_nxt = RS_IDLE;
    end

    always_comb begin
        en.frm = cnt_all | bypass | ~oof_in;
        en.rei = cnt_all | bypass | ~oof_in;
        en.par = cnt_all | bypass | (~oof_in & ~oof_fall & ~hold_busy);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oof_q        <= 1'b0;
            res_q        <= 1'b0;
            force_search <= 1'b0;
            hold_cnt     <= '0;
            rs_st        <= RS_IDLE;
        end else begin
            oof_q        <= oof_in;
            res_q        <= resync_ctl;
            force_search <= res_rise;
            rs_st        <= rs_nxt;
            if (oof_fall)
                hold_cnt <= HOLD_LOAD;
            else if (frame_stb && hold_busy)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end

    AST_FORCE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        force_search |=> !force_search);                                  // R4
    AST_FORCE_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
        force_search |-> $past(resync_ctl));                              // R4
    AST_HOLD_LOADED: assert property (@(posedge clk) disable iff (rst)
        (oof_q && !oof_in) |=> hold_cnt == HOLD_LOAD);                    // R2

endmodule

// File: rtl/plcp_em_status.sv
`timescale 1ns/1ps
module plcp_em_status
    import plcp_em_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_stb,
    input  g1_fields_t g1,
    input  logic       oof_in,
    input  logic       lof_in,
    output logic       rai_stat,
    output logic       oof_stat,
    output logic       lof_stat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rai_stat <= 1'b0;
            oof_stat <= 1'b0;
            lof_stat <= 1'b0;
        end else begin
            oof_stat <= oof_in;
            lof_stat <= lof_in;
            if (frame_stb) rai_stat <= g1.rai;
        end
    end

    AST_RAI_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(rai_stat));                                // R7
    AST_LOF_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        lof_in |=> lof_stat);                                             // R8

endmodule

// File: rtl/plcp_rx_errmon.sv
`timescale 1ns/1ps
module plcp_rx_errmon
    import plcp_em_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int REI_W       = 4,
    parameter int HOLD_FRAMES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_stb,
    input  logic             frm_err,
    input  logic             par_err,
    input  logic [7:0]       g1_byte,
    input  logic             oof_in,
    input  logic             lof_in,
    input  logic             lock_in,
    input  logic             cnt_all,
    input  logic             resync_ctl,
    input  logic             snap_stb,
    output logic             force_search,
    output logic [CNT_W-1:0] frm_cnt,
    output logic [CNT_W-1:0] par_cnt,
    output logic [CNT_W-1:0] rei_cnt,
    output logic             frm_nz,
    output logic             par_nz,
    output logic             rei_nz,
    output logic             rai_stat,
    output logic             oof_stat,
    output logic             lof_stat
);
    g1_fields_t       g1;
    em_enable_t       en;
    logic             bypass;
    logic             hold_busy;
    logic [REI_W-1:0] inc_v  [N_CTR];
    logic             en_v   [N_CTR];
    logic [CNT_W-1:0] live_v [N_CTR];
    logic [CNT_W-1:0] held_v [N_CTR];

    assign g1 = split_g1(g1_byte);

    plcp_em_gate #(.HOLD_FRAMES(HOLD_FRAMES)) u_gate (
        .clk          (clk),
        .rst          (rst),
        .frame_stb    (frame_stb),
        .oof_in       (oof_in),
        .lock_in      (lock_in),
        .cnt_all      (cnt_all),
        .resync_ctl   (resync_ctl),
        .force_search (force_search),
        .bypass       (bypass),
        .hold_busy    (hold_busy),
        .en           (en)
    );

    always_comb begin
        inc_v[CTR_FRM] = REI_W'(frm_err);
        inc_v[CTR_PAR] = REI_W'(par_err);
        inc_v[CTR_REI] = frame_stb ? REI_W'(g1.rei) : '0;
        en_v[CTR_FRM]  = en.frm;
        en_v[CTR_PAR]  = en.par;
        en_v[CTR_REI]  = en.rei;
    end

    for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
        plcp_em_counter #(.W(CNT_W), .IW(REI_W)) u_ctr (
            .clk  (clk),
            .rst  (rst),
            .en   (en_v[i]),
            .snap (snap_stb),
            .inc  (inc_v[i]),
            .live (live_v[i]),
            .held (held_v[i])
        );
    end

    plcp_em_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .g1        (g1),
        .oof_in    (oof_in),
        .lof_in    (lof_in),
        .rai_stat  (rai_stat),
        .oof_stat  (oof_stat),
        .lof_stat  (lof_stat)
    );

    assign frm_cnt = held_v[CTR_FRM];
    assign par_cnt = held_v[CTR_PAR];
    assign rei_cnt = held_v[CTR_REI];
    assign frm_nz  = |held_v[CTR_FRM];
    assign par_nz  = |held_v[CTR_PAR];
    assign rei_nz  = |held_v[CTR_REI];

    AST_OOF_GATES_FRM: assert property (@(posedge clk) disable iff (rst)
        (!cnt_all && oof_in && !bypass && !snap_stb) |=> $stable(live_v[CTR_FRM])); // R1
    AST_OOF_GATES_REI: assert property (@(posedge clk) disable iff (rst)
        (!cnt_all && oof_in && !bypass && !snap_stb) |=> $stable(live_v[CTR_REI])); // R1
    AST_PAR_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
        (!cnt_all && hold_busy && !bypass && !snap_stb) |=> $stable(live_v[CTR_PAR])); // R2
    AST_ALL_COUNTS_FRM: assert property (@(posedge clk) disable iff (rst)
        (cnt_all && frm_err && !snap_stb && live_v[CTR_FRM] != '1)
            |=> live_v[CTR_FRM] == $past(live_v[CTR_FRM]) + 1'b1);  // R3

endmodule

// File: tb/test_plcp_rx_errmon.sv
`timescale 1ns/1ps
module test_plcp_rx_errmon;
    localparam int W = 16;
    localparam logic [W-1:0] TOP = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_stb = 0, frm_err = 0, par_err = 0, oof_in = 0, lof_in = 0;
    logic lock_in = 0, cnt_all = 0, resync_ctl = 0, snap_stb = 0;
    logic [7:0] g1_byte = 8'h00;
    logic force_search, frm_nz, par_nz, rei_nz, rai_stat, oof_stat, lof_stat;
    logic [W-1:0] frm_cnt, par_cnt, rei_cnt;

    always #5 clk = ~clk;

    plcp_rx_errmon i_plcp_rx_errmon (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .frm_err(frm_err),
        .par_err(par_err), .g1_byte(g1_byte), .oof_in(oof_in), .lof_in(lof_in),
        .lock_in(lock_in), .cnt_all(cnt_all), .resync_ctl(resync_ctl),
        .snap_stb(snap_stb), .force_search(force_search), .frm_cnt(frm_cnt),
        .par_cnt(par_cnt), .rei_cnt(rei_cnt), .frm_nz(frm_nz), .par_nz(par_nz),
        .rei_nz(rei_nz), .rai_stat(rai_stat), .oof_stat(oof_stat), .lof_stat(lof_stat)
    );

    int n_run = 0, n_fail = 0;
    string cur_tag = "R12";
    bit done = 0;

    // Reference model state
    logic [W-1:0] m_live [3];
    logic [W-1:0] m_held [3];
    int   m_hold, m_st;  // st: 0 idle, 1 wait lock, 2 bypass
    logic m_oofq, m_resq, m_force, m_rai, m_oofo, m_lofo;

    function automatic logic [W-1:0] sat_add(input logic [W-1:0] a, input int b);
        int s = int'(a) + b;
        return (s > int'(TOP)) ? TOP : W'(s);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin m_live[i] = '0; m_held[i] = '0; end
        m_hold = 0; m_st = 0;
        {m_oofq, m_resq, m_force, m_rai, m_oofo, m_lofo} = '0;
    endtask

    task automatic model_step();
        logic fall, rise, byp, ok, pok;
        int inc [3];
        if (rst) begin model_reset(); return; end
        fall = m_oofq & ~oof_in;
        rise = resync_ctl & ~m_resq;
        byp  = (m_st == 2);
        ok   = cnt_all | byp | ~oof_in;
        pok  = cnt_all | byp | (~oof_in & ~fall & (m_hold == 0));
        inc[0] = (ok && frm_err) ? 1 : 0;
        inc[1] = (pok && par_err) ? 1 : 0;
        inc[2] = (ok && frame_stb) ? int'(g1_byte[7:4]) : 0;
        for (int i = 0; i < 3; i++) begin
            if (snap_stb) begin
                m_held[i] = m_live[i];
                m_live[i] = sat_add('0, inc[i]);
            end else
                m_live[i] = sat_add(m_live[i], inc[i]);
        end
        if (rise) m_st = 1;
        else if (m_st == 1 && lock_in) m_st = 2;
        else if (m_st == 2 && fall) m_st = 0;
        if (fall) m_hold = 2;
        else if (frame_stb && m_hold != 0) m_hold--;
        m_force = rise;
        m_resq  = resync_ctl;
        m_oofq  = oof_in;
        if (frame_stb) m_rai = g1_byte[3];
        m_oofo = oof_in;
        m_lofo = lof_in;
    endtask

    task automatic compare();
        chk({cur_tag, " frm count"}, frm_cnt, m_held[0]);
        chk({cur_tag, " par count"}, par_cnt, m_held[1]);
        chk({cur_tag, " rei count"}, rei_cnt, m_held[2]);
        chk("R6 nonzero flags", {frm_nz, par_nz, rei_nz},
            {m_held[0] != 0, m_held[1] != 0, m_held[2] != 0});
        chk("R4 force_search", force_search, m_force);
        chk("R7 rai_stat", rai_stat, m_rai);
        chk("R8 oof/lof status", {oof_stat, lof_stat}, {m_oofo, m_lofo});
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
        compare();
        {frm_err, par_err, frame_stb, snap_stb} = '0;
    endtask

    task automatic snap();
        snap_stb = 1; tick();
    endtask

    task automatic frame(input logic [7:0] g);
        frame_stb = 1; g1_byte = g; tick();
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C4A));
        model_reset();
        @(negedge clk);
        tick(); tick();
        rst = 0;
        cur_tag = "R12";
        chk("R12 reset force", force_search, 0);
        chk("R12 reset counts", frm_cnt | par_cnt | rei_cnt, 0);

        // R9: basic increments
        cur_tag = "R9";
        frm_err = 1; par_err = 1; tick();
        frm_err = 1; tick();
        frame(8'hA8);
        frame(8'h30);
        snap(); tick();
        chk("R9 rei sum", rei_cnt, 13);

        // R11: snapshot with same-cycle event
        cur_tag = "R11";
        frm_err = 1; par_err = 1; snap_stb = 1; tick();
        snap(); tick();
        chk("R11 event in cleared counter", frm_cnt, 1);

        // R1: out of frame, count control low
        cur_tag = "R1";
        oof_in = 1; tick();
        repeat (4) begin frm_err = 1; par_err = 1; frame(8'hF0); end
        snap(); tick();
        chk("R1 gated frm", frm_cnt, 0);

        // R2: holdoff after OOF falls mid frame
        cur_tag = "R2";
        par_err = 1; oof_in = 0; tick();
        repeat (3) begin par_err = 1; tick(); end
        par_err = 1; frame(8'h00);
        repeat (3) begin par_err = 1; tick(); end
        snap(); tick();
        chk("R2 first full frame held off", par_cnt, 0);
        par_err = 1; frame(8'h00);
        repeat (3) begin par_err = 1; tick(); end
        snap(); tick();
        chk("R2 second full frame counted", par_cnt, 3);

        // R3: count all during OOF
        cur_tag = "R3";
        cnt_all = 1; oof_in = 1; tick();
        repeat (5) begin frm_err = 1; par_err = 1; frame(8'h20); end
        snap(); tick();
        chk("R3 count during oof", par_cnt, 5);
        cnt_all = 0;

        // R4 / R5: forced resync, hold high, lock bypass
        cur_tag = "R5";
        resync_ctl = 1; repeat (6) tick();
        repeat (2) begin frm_err = 1; tick(); end
        lock_in = 1; tick(); lock_in = 0;
        repeat (3) begin frm_err = 1; par_err = 1; frame(8'h10); end
        snap(); tick();
        chk("R5 bypass counts", frm_cnt, 3);
        resync_ctl = 0; tick();
        resync_ctl = 1; tick(); tick();
        oof_in = 0; tick();
        frm_err = 1; par_err = 1; tick();
        resync_ctl = 0;
        snap(); tick();

        // R10: saturation through REI
        cur_tag = "R10";
        cnt_all = 1;
        repeat (4400) frame(8'hF0);
        snap(); tick();
        chk("R10 saturated", rei_cnt, int'(TOP));
        frame(8'hF0); snap(); tick();
        cnt_all = 0;

        // Random mix
        cur_tag = "R9";
        for (int k = 0; k < 6000; k++) begin
            frm_err    = ($urandom % 4) == 0;
            par_err    = ($urandom % 3) == 0;
            frame_stb  = ($urandom % 8) == 0;
            g1_byte    = 8'($urandom);
            snap_stb   = ($urandom % 50) == 0;
            lof_in     = ($urandom % 16) == 0;
            lock_in    = ($urandom % 10) == 0;
            if (($urandom % 40) == 0) oof_in = ~oof_in;
            if (($urandom % 200) == 0) cnt_all = ~cnt_all;
            if (($urandom % 60) == 0) resync_ctl = ~resync_ctl;
            tick();
        end
        snap(); tick();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule